// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight peripheral interrupt requests and picks one by fixed priority. Line 0 ranks highest and line 7 lowest. It presents a single interrupt output to the processor. When the processor acknowledges, the block returns an 8-bit vector that names the winning line, built from a programmable 5-bit base and the 3-bit line number. The block keeps a record of which levels are being serviced, so handlers can nest. A request can only interrupt the processor when it ranks strictly above every level already in service. An end-of-interrupt pulse retires the highest-ranked level in service.

Each line can be masked. A masked request is held as pending and appears as soon as the mask is lifted. Line 2 is reserved for a second controller: its request comes from the cascade input instead of the ordinary request pin. When line 2 wins an acknowledge, the block pulses a cascade-acknowledge output in place of a vector, so that the second controller can supply its own. Chaining two controllers this way gives fifteen usable request lines.

Top module: `pri_irq_ctrl`

## Requirements
- R1: After reset, `int_out`, `vec_valid` and `casc_ack` are 0. No line is pending, none is in service, the mask is 0x00 (all lines enabled) and the base is 0.
- R2: A request that is high at a clock edge sets that line's pending bit and stays pending after the request drops. If the line is eligible, `int_out` is high after the following edge.
- R3: On a cycle with `inta` high and an eligible line, the lowest-numbered eligible line wins. After that edge, `vec_out` = {base, line number} (base in bits 7:3, line in bits 2:0) and `vec_valid` is high for exactly one cycle.
- R4: A line whose mask bit is 1 never raises `int_out` and never wins. Its pending bit is kept, so clearing the mask bit lets it interrupt.
- R5: A pending line is eligible only when its number is lower than that of every line in service. Requests at or below the highest in-service level stay pending and hold `int_out` low.
- R6: An acknowledge clears the winning line's pending bit and sets its in-service bit.
- R7: An `eoi` pulse clears the lowest-numbered (highest-priority) set in-service bit only. Lower levels that were blocked become eligible again.
- R8: Line 2 takes its request from `casc_req`, and `irq_req[2]` has no effect. When line 2 wins an acknowledge, `casc_ack` pulses for one cycle and `vec_valid` stays low.
- R9: An acknowledge with no eligible line gives `vec_out` = {base, 7} with `vec_valid` high, and changes no pending or in-service state.
- R10: A `base_wr` pulse loads `base_data` as the vector base used by later acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Peripheral request lines (bit 2 unused when cascading) |
| casc_req | input | 1 | Interrupt output of the second controller, routed to line 2 |
| mask_wr | input | 1 | Load the mask register |
| mask_data | input | 8 | New mask, 1 = line suppressed |
| base_wr | input | 1 | Load the vector base |
| base_data | input | 5 | New vector base |
| inta | input | 1 | Processor interrupt acknowledge, one cycle per acknowledge |
| eoi | input | 1 | End-of-interrupt pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector for the acknowledged line |
| vec_valid | output | 1 | vec_out is valid this cycle |
| casc_ack | output | 1 | Acknowledge passed on to the second controller |

## Verification
Directed sequences separate the priority order from the nesting rule. A lower-ranked line that is pending during a higher handler must stay silent, while a higher-ranked arrival must break through. Retiring levels with end-of-interrupt must reveal the blocked line in the right order. Other directed cases cover a masked line that keeps its pending state, a request on pin 2 that must do nothing while the cascade input must work, and an acknowledge with nothing eligible. Random mixes of overlapping requests, acknowledges, end-of-interrupt pulses and mask and base writes run against a reference model. These expose errors in the order of clear and set within one cycle, and in end-of-interrupt arriving together with an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE     = 2'd0,
    ACK_VECTOR   = 2'd1,
    ACK_CASCADE  = 2'd2,
    ACK_SPURIOUS = 2'd3
  } ack_kind_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] clr,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_in,
  output logic [N-1:0] pend,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= (pend & ~clr) | req_in;
      if (mask_wr) mask <= mask_in;
    end
  end

  // pending state is only dropped by an acknowledge, never by masking
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (clr == '0) |=> (($past(pend) & ~pend) == '0)); // R4
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  output logic          any,
  output logic [IW-1:0] sel
);
  logic blocked;
  always_comb begin
    blocked = 1'b0;
    any     = 1'b0;
    sel     = '0;
    for (int i = 0; i < N; i++) begin
      blocked = blocked | isr[i];
      if (!any && pend[i] && !mask[i] && !blocked) begin
        any = 1'b1;
        sel = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          eoi,
  output logic [N-1:0]  isr
);
  logic [N-1:0] top_bit;
  logic [N-1:0] set_vec;

  assign top_bit = isr & (~isr + N'(1));
  assign set_vec = set_en ? (N'(1) << set_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= (isr & ~(eoi ? top_bit : '0)) | set_vec;
  end

  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (eoi && !set_en && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R7
  AST_NEST_HIGHER: assert property (@(posedge clk) disable iff (rst)
    (set_en && isr != '0) |-> ((N'(1) << set_idx) < top_bit)); // R5
endmodule

// File: rtl/pri_irq_ctrl.sv
module pri_irq_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int BASE_W    = 5,
  parameter int CASC_LINE = 2,
  parameter bit CASC_EN   = 1'b1,
  localparam int IW       = $clog2(NUM_LINES),
  localparam int VW       = BASE_W + IW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 casc_req,
  input  logic                 mask_wr,
  input  logic [NUM_LINES-1:0] mask_data,
  input  logic                 base_wr,
  input  logic [BASE_W-1:0]    base_data,
  input  logic                 inta,
  input  logic                 eoi,
  output logic                 int_out,
  output logic [VW-1:0]        vec_out,
  output logic                 vec_valid,
  output logic                 casc_ack
);
  import irq_pkg::*;

  logic [NUM_LINES-1:0] req_eff, pend, mask, isr, clr;
  logic [BASE_W-1:0]    base;
  logic                 any;
  logic [IW-1:0]        sel;
  logic                 ack_hit;
  ack_kind_e            kind;

  generate
    if (CASC_EN) begin : g_casc
      always_comb begin
        req_eff            = irq_req;
        req_eff[CASC_LINE] = casc_req;
      end
    end else begin : g_plain
      assign req_eff = irq_req;
    end
  endgenerate

  assign ack_hit = inta & any;
  assign clr     = ack_hit ? (NUM_LINES'(1) << sel) : '0;

  always_comb begin
    if (!inta)                              kind = ACK_IDLE;
    else if (!any)                          kind = ACK_SPURIOUS;
    else if (CASC_EN && sel == IW'(CASC_LINE)) kind = ACK_CASCADE;
    else                                    kind = ACK_VECTOR;
  end

  irq_pending #(.N(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .req_in(req_eff), .clr(clr),
    .mask_wr(mask_wr), .mask_in(mask_data), .pend(pend), .mask(mask)
  );

  irq_resolve #(.N(NUM_LINES), .IW(IW)) u_res (
    .pend(pend), .mask(mask), .isr(isr), .any(any), .sel(sel)
  );

  irq_inservice #(.N(NUM_LINES), .IW(IW)) u_isr (
    .clk(clk), .rst(rst), .set_en(ack_hit), .set_idx(sel),
    .eoi(eoi), .isr(isr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      int_out   <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      casc_ack  <= 1'b0;
    end else begin
      if (base_wr) base <= base_data;
      int_out   <= any;
      vec_valid <= (kind == ACK_VECTOR) || (kind == ACK_SPURIOUS);
      casc_ack  <= (kind == ACK_CASCADE);
      case (kind)
        ACK_VECTOR, ACK_CASCADE: vec_out <= {base, sel};
        ACK_SPURIOUS:            vec_out <= {base, IW'(NUM_LINES - 1)};
        default:                 vec_out <= vec_out;
      endcase
    end
  end

  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (rst)
    !inta |=> (!vec_valid && !casc_ack)); // R3
  AST_CASC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(vec_valid && casc_ack)); // R8
  AST_INT_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ($past(pend) != '0)); // R2
endmodule

// File: tb/pri_irq_ctrl_test.sv
module pri_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_req;
  logic       casc_req, mask_wr, base_wr, inta, eoi;
  logic [7:0] mask_data;
  logic [4:0] base_data;
  logic       int_out, vec_valid, casc_ack;
  logic [7:0] vec_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0] m_pend, m_isr, m_mask;
  logic [4:0] m_base;
  logic       e_int, e_vv, e_ca;
  logic [7:0] e_vec;

  always #5 clk = ~clk;

  pri_irq_ctrl uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .casc_req(casc_req),
    .mask_wr(mask_wr), .mask_data(mask_data), .base_wr(base_wr),
    .base_data(base_data), .inta(inta), .eoi(eoi), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .casc_ack(casc_ack)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model advanced by one edge from the current drive values
  task automatic model_edge();
    logic [7:0] reqe, clr;
    logic any, seen;
    logic [2:0] sel;
    if (rst) begin
      m_pend = 0; m_isr = 0; m_mask = 0; m_base = 0;
      e_int = 0; e_vv = 0; e_ca = 0; e_vec = 0;
      return;
    end
    reqe = irq_req; reqe[2] = casc_req;
    any = 0; seen = 0; sel = 0;
    for (int i = 0; i < 8; i++) begin
      seen = seen | m_isr[i];
      if (!any && m_pend[i] && !m_mask[i] && !seen) begin any = 1; sel = 3'(i); end
    end
    e_int = any;
    if (inta) begin
      if (any) begin e_vec = {m_base, sel}; e_vv = (sel != 3'd2); e_ca = (sel == 3'd2); end
      else begin e_vec = {m_base, 3'd7}; e_vv = 1; e_ca = 0; end
    end else begin e_vv = 0; e_ca = 0; end
    clr = (inta && any) ? (8'd1 << sel) : 8'd0;
    m_pend = (m_pend & ~clr) | reqe;
    if (eoi) m_isr = m_isr & ~(m_isr & (~m_isr + 8'd1));
    m_isr = m_isr | clr;
    if (mask_wr) m_mask = mask_data;
    if (base_wr) m_base = base_data;
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk("R2 int_out", {7'd0, int_out}, {7'd0, e_int});
    chk("R3 vec_valid", {7'd0, vec_valid}, {7'd0, e_vv});
    chk("R8 casc_ack", {7'd0, casc_ack}, {7'd0, e_ca});
    if (e_vv || e_ca) chk("R3 vec_out", vec_out, e_vec);
  endtask

  task automatic idle();
    irq_req = 0; casc_req = 0; mask_wr = 0; mask_data = 0;
    base_wr = 0; base_data = 0; inta = 0; eoi = 0;
  endtask

  task automatic pulse_ack();
    inta = 1; step(); inta = 0;
  endtask

  task automatic pulse_eoi();
    eoi = 1; step(); eoi = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd4242);
    idle();
    rst = 1;
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 int_out", {7'd0, int_out}, 8'd0);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    chk("R1 casc_ack", {7'd0, casc_ack}, 8'd0);

    // R10 base load, R2 pending and interrupt
    base_wr = 1; base_data = 5'h15; step(); base_wr = 0;
    irq_req = 8'h28; step(); irq_req = 0; step();
    chk("R2 int after request", {7'd0, int_out}, 8'd1);
    // R3 lowest line wins
    pulse_ack();
    chk("R3 vec_valid", {7'd0, vec_valid}, 8'd1);
    chk("R3 vector line3", vec_out, 8'hAB);
    step();
    chk("R3 single cycle", {7'd0, vec_valid}, 8'd0);
    chk("R5 lower blocked", {7'd0, int_out}, 8'd0);
    // R5 higher level preempts
    irq_req = 8'h02; step(); irq_req = 0; step();
    chk("R5 higher preempts", {7'd0, int_out}, 8'd1);
    pulse_ack();
    chk("R5 nested vector", vec_out, 8'hA9);
    // R7 eoi retires the top level only
    pulse_eoi(); step();
    chk("R7 line3 still blocks", {7'd0, int_out}, 8'd0);
    pulse_eoi(); step();
    chk("R7 line5 released", {7'd0, int_out}, 8'd1);
    pulse_ack();
    chk("R7 vector line5", vec_out, 8'hAD);
    pulse_eoi();

    // R4 mask keeps pending
    mask_wr = 1; mask_data = 8'h10; step(); mask_wr = 0;
    irq_req = 8'h10; step(); irq_req = 0; step(); step();
    chk("R4 masked silent", {7'd0, int_out}, 8'd0);
    mask_wr = 1; mask_data = 8'h00; step(); mask_wr = 0; step();
    chk("R4 unmasked fires", {7'd0, int_out}, 8'd1);
    pulse_ack();
    chk("R4 vector line4", vec_out, 8'hAC);
    pulse_eoi();
    // R6 acknowledged request is no longer pending
    step(); step();
    chk("R6 pending cleared", {7'd0, int_out}, 8'd0);

    // R8 cascade routing
    irq_req = 8'h04; step(); irq_req = 0; step(); step();
    chk("R8 pin2 ignored", {7'd0, int_out}, 8'd0);
    casc_req = 1; step(); casc_req = 0; step();
    chk("R8 cascade int", {7'd0, int_out}, 8'd1);
    pulse_ack();
    chk("R8 casc_ack", {7'd0, casc_ack}, 8'd1);
    chk("R8 no vector", {7'd0, vec_valid}, 8'd0);
    pulse_eoi();

    // R9 spurious acknowledge
    step();
    pulse_ack();
    chk("R9 spurious valid", {7'd0, vec_valid}, 8'd1);
    chk("R9 spurious vector", vec_out, 8'hAF);
    step();
    chk("R9 no state change", {7'd0, int_out}, 8'd0);

    // R10 new base
    base_wr = 1; base_data = 5'h03; step(); base_wr = 0;
    irq_req = 8'h80; step(); irq_req = 0; step();
    pulse_ack();
    chk("R10 new base vector", vec_out, 8'h1F);
    pulse_eoi();

    // random mix checked against the model
    for (int k = 0; k < 3000; k++) begin
      irq_req   = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      casc_req  = ($urandom % 8 == 0);
      inta      = ($urandom % 6 == 0);
      eoi       = ($urandom % 6 == 0);
      mask_wr   = ($urandom % 40 == 0);
      mask_data = 8'($urandom) & 8'h5A;
      base_wr   = ($urandom % 50 == 0);
      base_data = 5'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule